// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state save and control transfer that happens when a core takes a trap. The core presents a one-cycle request: either a trap with its cause code, or a failed bus access with a flag that tells whether it was an instruction fetch. Along with the request come the program counter of the trapping instruction, the instruction word, the index of the interrupt line that won arbitration, a flag that says a translation-refill handler is running, and the entry base addresses. At the clock edge that ends the request cycle, the block updates its mode, saved-mode, return-address, cause, bad-instruction and debug registers. In the cycle after the request it presents the new fetch address on `redirect_pc` and raises `redirect_valid` for that one cycle.

A request takes one of three routes. The debug route is used for a debug breakpoint, and also for an interrupt that arrives while debug mode is already active. The refill route is used for any other request while a refill is in progress. The normal route is used otherwise. Each route writes its own saved-mode and return registers and has its own target rule. The core can load the current mode register through a small write port. A request with a cause code the block does not know raises `code_err` and changes nothing.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset, the outputs take these values: `plv`=0, `ie`=0, `da`=1, `pg`=0, `datf`=1, `datm`=1, `redirect_valid`=0, `redirect_pc`=0x1C000000. All saved, return, cause, bad-instruction and debug outputs are 0, and `code_err` is 0.
- R2: A supported request on the normal route does four things: it writes the cause code to `cause_code`, copies `plv`/`ie` into `saved_plv`/`saved_ie`, writes `cur_pc` to `ret_pc`, and targets `entry_base + code*vec_space`. The supported codes are 0 (interrupt), 1 (load page invalid), 2 (store page invalid), 3 (fetch page invalid), 4 (page modified), 5 (not readable), 6 (not executable), 7 (page privilege), 8 (fetch address error), 9 (data address error), 0x0B (syscall), 0x0C (break), 0x0D (undefined opcode), 0x0E (opcode privilege), 0x0F (floating-point) and 0x1A (debug breakpoint).
- R3: Every entry on the normal or refill route sets `plv` to 0 and `ie` to 0.
- R4: A supported request on the refill route does the following. It copies `plv`/`ie` into `rf_saved_plv`/`rf_saved_ie`, sets `da`=1 and `pg`=0, and writes `cur_pc>>2` to `rf_ret_pc`. It leaves `cause_code`, `saved_*` and `ret_pc` unchanged. Its target is `refill_base` for every cause except an interrupt.
- R5: An interrupt (code 0) taken on the normal or refill route targets `entry_base + (64 + int_line)*vec_space`.
- R6: `bad_insn` takes `fault_insn` on normal and refill entries, except for interrupts and for code 3, where it keeps its value. It is also left unchanged on debug entries.
- R7: A debug breakpoint (code 0x1A) sets `dbg_bp`=1, `dbg_code`=0x0C and `dbg_active`=1, writes `cur_pc` to `dbg_ret_pc`, and targets `entry_base + 0x480`. It leaves the mode, saved-mode, return, cause and bad-instruction outputs unchanged.
- R8: An interrupt taken while `dbg_active`=1 follows the debug route. It sets `dbg_int`=1, writes `dbg_ret_pc`, and targets `entry_base + 0x480`. It leaves `dbg_bp` and `dbg_code` unchanged.
- R9: A bus fault (`bus_fault`=1 with `exc_valid`=0) enters with code 8 if `bus_fault_fetch`=1 and with code 9 otherwise. When `exc_valid` and `bus_fault` are both high, the code on `exc_code` is used.
- R10: A request with an unsupported code raises `code_err` for one cycle. It raises no redirect and changes no other output.
- R11: For a supported request, `redirect_valid` is high in exactly the cycle after the request cycle. `redirect_pc` keeps its value until the next entry.
- R12: `mode_wr_en` loads `plv`, `ie`, `da` and `pg` at the next edge, unless a request is present in the same cycle. A request in that cycle blocks the write, whether or not its code is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | One-cycle trap request |
| exc_code | input | 6 | Cause code of the trap request |
| bus_fault | input | 1 | One-cycle failed bus access |
| bus_fault_fetch | input | 1 | Failed access was an instruction fetch |
| int_line | input | IDXW | Winning interrupt line index |
| cur_pc | input | PCW | PC of the trapping instruction |
| fault_insn | input | INSW | Instruction word of the trapping instruction |
| refill_active | input | 1 | Translation-refill handler in progress |
| entry_base | input | PCW | Base of the normal and debug entry area |
| refill_base | input | PCW | Refill handler entry address |
| vec_space | input | SPW | Spacing between vectored entries |
| mode_wr_en | input | 1 | Load the mode register |
| mode_wr_plv | input | 2 | Privilege level to load |
| mode_wr_ie | input | 1 | Interrupt enable to load |
| mode_wr_da | input | 1 | Direct-address mode to load |
| mode_wr_pg | input | 1 | Paging mode to load |
| plv | output | 2 | Current privilege level |
| ie | output | 1 | Current interrupt enable |
| da | output | 1 | Direct-address mode |
| pg | output | 1 | Paging mode |
| datf | output | 2 | Direct-access fetch memory type |
| datm | output | 2 | Direct-access data memory type |
| saved_plv | output | 2 | Privilege level saved on normal entry |
| saved_ie | output | 1 | Interrupt enable saved on normal entry |
| rf_saved_plv | output | 2 | Privilege level saved on refill entry |
| rf_saved_ie | output | 1 | Interrupt enable saved on refill entry |
| ret_pc | output | PCW | Return address of normal entry |
| rf_ret_pc | output | PCW-2 | Word return address of refill entry |
| dbg_ret_pc | output | PCW | Return address of debug entry |
| cause_code | output | 6 | Cause of the last normal entry |
| bad_insn | output | INSW | Captured instruction word |
| dbg_active | output | 1 | Debug mode flag |
| dbg_bp | output | 1 | Debug entry caused by breakpoint |
| dbg_int | output | 1 | Debug entry caused by interrupt |
| dbg_code | output | 6 | Debug cause code |
| redirect_valid | output | 1 | New fetch address valid |
| redirect_pc | output | PCW | New fetch address |
| code_err | output | 1 | Unsupported cause code seen |

## Verification
A wrong route decision shows up in the first cycle after the request, because the save registers of the other route move and the redirect target changes at the same edge. A stale or mis-latched mode register does not show up on its own. It appears only at the next entry, when the wrong `plv`/`ie` pair is copied into a saved-mode register. For that reason, each sweep step loads a fresh mode value just before the request. The debug flag is sticky, so an error in it stays hidden until an interrupt arrives and is routed the wrong way.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_NORMAL,
    PATH_REFILL,
    PATH_DEBUG
  } entry_path_e;

  localparam logic [CODE_W-1:0] C_INT      = 6'h00;
  localparam logic [CODE_W-1:0] C_PG_LD    = 6'h01;
  localparam logic [CODE_W-1:0] C_PG_ST    = 6'h02;
  localparam logic [CODE_W-1:0] C_PG_IF    = 6'h03;
  localparam logic [CODE_W-1:0] C_PG_MOD   = 6'h04;
  localparam logic [CODE_W-1:0] C_NO_RD    = 6'h05;
  localparam logic [CODE_W-1:0] C_NO_EX    = 6'h06;
  localparam logic [CODE_W-1:0] C_PG_PRIV  = 6'h07;
  localparam logic [CODE_W-1:0] C_ADR_IF   = 6'h08;
  localparam logic [CODE_W-1:0] C_ADR_MEM  = 6'h09;
  localparam logic [CODE_W-1:0] C_SYSCALL  = 6'h0B;
  localparam logic [CODE_W-1:0] C_BREAK    = 6'h0C;
  localparam logic [CODE_W-1:0] C_BAD_OP   = 6'h0D;
  localparam logic [CODE_W-1:0] C_OP_PRIV  = 6'h0E;
  localparam logic [CODE_W-1:0] C_FPU      = 6'h0F;
  localparam logic [CODE_W-1:0] C_DBG_BP   = 6'h1A;

  localparam logic [CODE_W-1:0] DBG_BP_CODE = 6'h0C;

  function automatic logic code_supported(input logic [CODE_W-1:0] c);
    case (c)
      C_INT, C_PG_LD, C_PG_ST, C_PG_IF, C_PG_MOD, C_NO_RD, C_NO_EX,
      C_PG_PRIV, C_ADR_IF, C_ADR_MEM, C_SYSCALL, C_BREAK, C_BAD_OP,
      C_OP_PRIV, C_FPU, C_DBG_BP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              bus_fault,
  input  logic              bus_fault_fetch,
  input  logic              dbg_active,
  input  logic              refill_active,
  output logic              req,
  output logic              supported,
  output logic [CODE_W-1:0] code,
  output entry_path_e       path,
  output logic              is_int,
  output logic              is_bp,
  output logic              take_badi
);

  always_comb begin
    req = exc_valid | bus_fault;
    if (exc_valid)            code = exc_code;
    else if (bus_fault_fetch) code = C_ADR_IF;
    else                      code = C_ADR_MEM;
    supported = code_supported(code);
    is_int    = (code == C_INT);
    is_bp     = (code == C_DBG_BP);
    take_badi = !is_int && (code != C_PG_IF);
    if (!req || !supported)              path = PATH_NONE;
    else if (is_bp || (is_int && dbg_active)) path = PATH_DEBUG;
    else if (refill_active)              path = PATH_REFILL;
    else                                 path = PATH_NORMAL;
  end

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int PCW           = 32,
  parameter int IDXW          = 4,
  parameter int SPW           = 8,
  parameter int INT_SLOT_BASE = 64,
  parameter int DBG_OFFSET    = 32'h480,
  parameter bit SPACE_LOG2    = 1'b0
)(
  input  entry_path_e       path,
  input  logic              is_int,
  input  logic [CODE_W-1:0] code,
  input  logic [IDXW-1:0]   int_line,
  input  logic [PCW-1:0]    entry_base,
  input  logic [PCW-1:0]    refill_base,
  input  logic [SPW-1:0]    vec_space,
  output logic [PCW-1:0]    target
);

  logic [PCW-1:0] slot;
  logic [PCW-1:0] offset;

  assign slot = is_int ? (PCW'(INT_SLOT_BASE) + PCW'(int_line)) : PCW'(code);

  generate
    if (SPACE_LOG2) begin : g_shift
      assign offset = slot << vec_space;
    end else begin : g_mult
      assign offset = slot * PCW'(vec_space);
    end
  endgenerate

  always_comb begin
    case (path)
      PATH_DEBUG:  target = entry_base + PCW'(DBG_OFFSET);
      PATH_REFILL: target = is_int ? (entry_base + offset) : refill_base;
      default:     target = entry_base + offset;
    endcase
  end

endmodule

// File: rtl/exc_mode_regs.sv
module exc_mode_regs
  import exc_entry_pkg::*;
#(
  parameter int PCW = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  entry_path_e       path,
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  input  logic [PCW-1:0]    cur_pc,
  input  logic              wr_en,
  input  logic [1:0]        wr_plv,
  input  logic              wr_ie,
  input  logic              wr_da,
  input  logic              wr_pg,
  output logic [1:0]        plv,
  output logic              ie,
  output logic              da,
  output logic              pg,
  output logic [1:0]        datf,
  output logic [1:0]        datm,
  output logic [1:0]        saved_plv,
  output logic              saved_ie,
  output logic [1:0]        rf_saved_plv,
  output logic              rf_saved_ie,
  output logic [PCW-1:0]    ret_pc,
  output logic [PCW-3:0]    rf_ret_pc,
  output logic [CODE_W-1:0] cause_code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      plv          <= 2'd0;
      ie           <= 1'b0;
      da           <= 1'b1;
      pg           <= 1'b0;
      datf         <= 2'd1;
      datm         <= 2'd1;
      saved_plv    <= 2'd0;
      saved_ie     <= 1'b0;
      rf_saved_plv <= 2'd0;
      rf_saved_ie  <= 1'b0;
      ret_pc       <= '0;
      rf_ret_pc    <= '0;
      cause_code   <= '0;
    end else begin
      case (path)
        PATH_NORMAL: begin
          cause_code <= code;
          saved_plv  <= plv;
          saved_ie   <= ie;
          ret_pc     <= cur_pc;
          plv        <= 2'd0;
          ie         <= 1'b0;
        end
        PATH_REFILL: begin
          rf_saved_plv <= plv;
          rf_saved_ie  <= ie;
          da           <= 1'b1;
          pg           <= 1'b0;
          rf_ret_pc    <= cur_pc[PCW-1:2];
          plv          <= 2'd0;
          ie           <= 1'b0;
        end
        PATH_DEBUG: begin
        end
        default: begin
          if (wr_en && !req) begin
            plv <= wr_plv;
            ie  <= wr_ie;
            da  <= wr_da;
            pg  <= wr_pg;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/exc_debug_regs.sv
module exc_debug_regs
  import exc_entry_pkg::*;
#(
  parameter int PCW = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  entry_path_e       path,
  input  logic              is_bp,
  input  logic [PCW-1:0]    cur_pc,
  output logic              dbg_active,
  output logic              dbg_bp,
  output logic              dbg_int,
  output logic [CODE_W-1:0] dbg_code,
  output logic [PCW-1:0]    dbg_ret_pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_active <= 1'b0;
      dbg_bp     <= 1'b0;
      dbg_int    <= 1'b0;
      dbg_code   <= '0;
      dbg_ret_pc <= '0;
    end else if (path == PATH_DEBUG) begin
      dbg_active <= 1'b1;
      dbg_ret_pc <= cur_pc;
      if (is_bp) begin
        dbg_bp   <= 1'b1;
        dbg_code <= DBG_BP_CODE;
      end else begin
        dbg_int  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          PCW           = 32,
  parameter int          IDXW          = 4,
  parameter int          SPW           = 8,
  parameter int          INSW          = 32,
  parameter int          INT_SLOT_BASE = 64,
  parameter int          DBG_OFFSET    = 32'h480,
  parameter bit          SPACE_LOG2    = 1'b0,
  parameter logic [31:0] RESET_PC      = 32'h1C00_0000
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              bus_fault,
  input  logic              bus_fault_fetch,
  input  logic [IDXW-1:0]   int_line,
  input  logic [PCW-1:0]    cur_pc,
  input  logic [INSW-1:0]   fault_insn,
  input  logic              refill_active,
  input  logic [PCW-1:0]    entry_base,
  input  logic [PCW-1:0]    refill_base,
  input  logic [SPW-1:0]    vec_space,
  input  logic              mode_wr_en,
  input  logic [1:0]        mode_wr_plv,
  input  logic              mode_wr_ie,
  input  logic              mode_wr_da,
  input  logic              mode_wr_pg,
  output logic [1:0]        plv,
  output logic              ie,
  output logic              da,
  output logic              pg,
  output logic [1:0]        datf,
  output logic [1:0]        datm,
  output logic [1:0]        saved_plv,
  output logic              saved_ie,
  output logic [1:0]        rf_saved_plv,
  output logic              rf_saved_ie,
  output logic [PCW-1:0]    ret_pc,
  output logic [PCW-3:0]    rf_ret_pc,
  output logic [PCW-1:0]    dbg_ret_pc,
  output logic [CODE_W-1:0] cause_code,
  output logic [INSW-1:0]   bad_insn,
  output logic              dbg_active,
  output logic              dbg_bp,
  output logic              dbg_int,
  output logic [CODE_W-1:0] dbg_code,
  output logic              redirect_valid,
  output logic [PCW-1:0]    redirect_pc,
  output logic              code_err
);

  logic              req;
  logic              supported;
  logic [CODE_W-1:0] code;
  entry_path_e       path;
  logic              is_int;
  logic              is_bp;
  logic              take_badi;
  logic [PCW-1:0]    target;

  exc_decode u_decode (
    .exc_valid       (exc_valid),
    .exc_code        (exc_code),
    .bus_fault       (bus_fault),
    .bus_fault_fetch (bus_fault_fetch),
    .dbg_active      (dbg_active),
    .refill_active   (refill_active),
    .req             (req),
    .supported       (supported),
    .code            (code),
    .path            (path),
    .is_int          (is_int),
    .is_bp           (is_bp),
    .take_badi       (take_badi)
  );

  exc_target #(
    .PCW           (PCW),
    .IDXW          (IDXW),
    .SPW           (SPW),
    .INT_SLOT_BASE (INT_SLOT_BASE),
    .DBG_OFFSET    (DBG_OFFSET),
    .SPACE_LOG2    (SPACE_LOG2)
  ) u_target (
    .path        (path),
    .is_int      (is_int),
    .code        (code),
    .int_line    (int_line),
    .entry_base  (entry_base),
    .refill_base (refill_base),
    .vec_space   (vec_space),
    .target      (target)
  );

  exc_mode_regs #(.PCW(PCW)) u_mode (
    .clk          (clk),
    .rst          (rst),
    .path         (path),
    .req          (req),
    .code         (code),
    .cur_pc       (cur_pc),
    .wr_en        (mode_wr_en),
    .wr_plv       (mode_wr_plv),
    .wr_ie        (mode_wr_ie),
    .wr_da        (mode_wr_da),
    .wr_pg        (mode_wr_pg),
    .plv          (plv),
    .ie           (ie),
    .da           (da),
    .pg           (pg),
    .datf         (datf),
    .datm         (datm),
    .saved_plv    (saved_plv),
    .saved_ie     (saved_ie),
    .rf_saved_plv (rf_saved_plv),
    .rf_saved_ie  (rf_saved_ie),
    .ret_pc       (ret_pc),
    .rf_ret_pc    (rf_ret_pc),
    .cause_code   (cause_code)
  );

  exc_debug_regs #(.PCW(PCW)) u_debug (
    .clk        (clk),
    .rst        (rst),
    .path       (path),
    .is_bp      (is_bp),
    .cur_pc     (cur_pc),
    .dbg_active (dbg_active),
    .dbg_bp     (dbg_bp),
    .dbg_int    (dbg_int),
    .dbg_code   (dbg_code),
    .dbg_ret_pc (dbg_ret_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_insn       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= PCW'(RESET_PC);
      code_err       <= 1'b0;
    end else begin
      redirect_valid <= (path != PATH_NONE);
      code_err       <= req && !supported;
      if (path != PATH_NONE) redirect_pc <= target;
      if (((path == PATH_NORMAL) || (path == PATH_REFILL)) && take_badi)
        bad_insn <= fault_insn;
    end
  end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int PCW = 32
)(
  input logic           clk,
  input logic           rst,
  input logic           exc_valid,
  input logic           bus_fault,
  input logic [PCW-1:0] entry_base,
  input logic [1:0]     plv,
  input logic           ie,
  input logic           da,
  input logic           pg,
  input logic [PCW-1:0] ret_pc,
  input logic [PCW-3:0] rf_ret_pc,
  input logic [5:0]     cause_code,
  input logic           dbg_active,
  input logic           redirect_valid,
  input logic [PCW-1:0] redirect_pc,
  input logic           code_err
);

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (plv == 2'd0) && !ie && da && !pg && !redirect_valid && !code_err);

  // R3: a non-debug entry leaves privilege 0 and interrupts off
  a_r3_entry_clears_mode: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && !dbg_active) |-> (plv == 2'd0) && !ie);

  // R4: refill return address only moves together with direct mode
  a_r4_refill_sets_da: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_ret_pc) |-> da && !pg);

  // R7: entering debug mode redirects to the debug slot
  a_r7_debug_target: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_active) |-> redirect_valid && (redirect_pc == $past(entry_base) + PCW'(32'h480)));

  // R10: unknown code changes nothing and redirects nowhere
  a_r10_err_no_effect: assert property (@(posedge clk) disable iff (rst)
    code_err |-> !redirect_valid && $stable(plv) && $stable(ie) && $stable(ret_pc)
                 && $stable(cause_code));

  // R11: a redirect follows a request by exactly one cycle
  a_r11_redirect_timing: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> $past(exc_valid || bus_fault));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.PCW(PCW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .exc_valid      (exc_valid),
  .bus_fault      (bus_fault),
  .entry_base     (entry_base),
  .plv            (plv),
  .ie             (ie),
  .da             (da),
  .pg             (pg),
  .ret_pc         (ret_pc),
  .rf_ret_pc      (rf_ret_pc),
  .cause_code     (cause_code),
  .dbg_active     (dbg_active),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .code_err       (code_err)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

  localparam logic [31:0] BASE  = 32'h1000_0000;
  localparam logic [31:0] RBASE = 32'h2000_0100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        exc_valid = 1'b0;
  logic [5:0]  exc_code = '0;
  logic        bus_fault = 1'b0;
  logic        bus_fault_fetch = 1'b0;
  logic [3:0]  int_line = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] fault_insn = '0;
  logic        refill_active = 1'b0;
  logic [31:0] entry_base = BASE;
  logic [31:0] refill_base = RBASE;
  logic [7:0]  vec_space = 8'd8;
  logic        mode_wr_en = 1'b0;
  logic [1:0]  mode_wr_plv = '0;
  logic        mode_wr_ie = 1'b0;
  logic        mode_wr_da = 1'b0;
  logic        mode_wr_pg = 1'b0;

  logic [1:0]  plv, datf, datm, saved_plv, rf_saved_plv;
  logic        ie, da, pg, saved_ie, rf_saved_ie;
  logic [31:0] ret_pc, dbg_ret_pc, bad_insn, redirect_pc;
  logic [29:0] rf_ret_pc;
  logic [5:0]  cause_code, dbg_code;
  logic        dbg_active, dbg_bp, dbg_int, redirect_valid, code_err;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .bus_fault(bus_fault), .bus_fault_fetch(bus_fault_fetch), .int_line(int_line),
    .cur_pc(cur_pc), .fault_insn(fault_insn), .refill_active(refill_active),
    .entry_base(entry_base), .refill_base(refill_base), .vec_space(vec_space),
    .mode_wr_en(mode_wr_en), .mode_wr_plv(mode_wr_plv), .mode_wr_ie(mode_wr_ie),
    .mode_wr_da(mode_wr_da), .mode_wr_pg(mode_wr_pg),
    .plv(plv), .ie(ie), .da(da), .pg(pg), .datf(datf), .datm(datm),
    .saved_plv(saved_plv), .saved_ie(saved_ie), .rf_saved_plv(rf_saved_plv),
    .rf_saved_ie(rf_saved_ie), .ret_pc(ret_pc), .rf_ret_pc(rf_ret_pc),
    .dbg_ret_pc(dbg_ret_pc), .cause_code(cause_code), .bad_insn(bad_insn),
    .dbg_active(dbg_active), .dbg_bp(dbg_bp), .dbg_int(dbg_int), .dbg_code(dbg_code),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .code_err(code_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // expected state, derived from the requirements
  logic [1:0]  m_plv, m_spl, m_rspl;
  logic        m_ie, m_da, m_pg, m_sie, m_rsie;
  logic [31:0] m_ret, m_dret, m_badi, m_rpc;
  logic [29:0] m_rret;
  logic [5:0]  m_cause, m_dcode;
  logic        m_dact, m_dbp, m_dint, m_rv, m_err;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit supp(input logic [5:0] c);
    return (c <= 6'h09) || (c >= 6'h0B && c <= 6'h0F) || (c == 6'h1A);
  endfunction

  task automatic model_reset();
    m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0; m_spl = 0; m_sie = 0;
    m_rspl = 0; m_rsie = 0; m_ret = 0; m_rret = 0; m_dret = 0; m_cause = 0;
    m_badi = 0; m_dact = 0; m_dbp = 0; m_dint = 0; m_dcode = 0;
    m_rpc = 32'h1C00_0000; m_rv = 0; m_err = 0;
  endtask

  task automatic compare_all(input string tag);
    chk("R3", "plv", 64'(plv), 64'(m_plv));
    chk("R3", "ie", 64'(ie), 64'(m_ie));
    chk("R4", "da", 64'(da), 64'(m_da));
    chk("R4", "pg", 64'(pg), 64'(m_pg));
    chk("R2", "saved_plv", 64'(saved_plv), 64'(m_spl));
    chk("R2", "saved_ie", 64'(saved_ie), 64'(m_sie));
    chk("R2", "ret_pc", 64'(ret_pc), 64'(m_ret));
    chk("R2", "cause_code", 64'(cause_code), 64'(m_cause));
    chk("R4", "rf_saved_plv", 64'(rf_saved_plv), 64'(m_rspl));
    chk("R4", "rf_saved_ie", 64'(rf_saved_ie), 64'(m_rsie));
    chk("R4", "rf_ret_pc", 64'(rf_ret_pc), 64'(m_rret));
    chk("R6", "bad_insn", 64'(bad_insn), 64'(m_badi));
    chk("R7", "dbg_active", 64'(dbg_active), 64'(m_dact));
    chk("R7", "dbg_bp", 64'(dbg_bp), 64'(m_dbp));
    chk("R7", "dbg_code", 64'(dbg_code), 64'(m_dcode));
    chk("R7", "dbg_ret_pc", 64'(dbg_ret_pc), 64'(m_dret));
    chk("R8", "dbg_int", 64'(dbg_int), 64'(m_dint));
    chk("R10", "code_err", 64'(code_err), 64'(m_err));
    chk("R11", "redirect_valid", 64'(redirect_valid), 64'(m_rv));
    chk(tag, "redirect_pc", 64'(redirect_pc), 64'(m_rpc));
  endtask

  // called at a negedge; loads the mode register
  task automatic mode_wr(input logic [1:0] p, input logic i, input logic d, input logic g);
    mode_wr_en = 1; mode_wr_plv = p; mode_wr_ie = i; mode_wr_da = d; mode_wr_pg = g;
    @(negedge clk);
    mode_wr_en = 0;
    m_plv = p; m_ie = i; m_da = d; m_pg = g; m_rv = 0; m_err = 0;
    chk("R12", "plv", 64'(plv), 64'(p));
    chk("R12", "ie", 64'(ie), 64'(i));
    chk("R12", "da", 64'(da), 64'(d));
    chk("R12", "pg", 64'(pg), 64'(g));
  endtask

  // called at a negedge; one request cycle, then all outputs checked
  task automatic fire(input logic ev, input logic [5:0] c, input logic bf, input logic bff,
                      input logic r, input logic [3:0] line, input logic [7:0] sp,
                      input logic [31:0] pc, input logic [31:0] insn, input string tag);
    logic [5:0] ec;
    exc_valid = ev; exc_code = c; bus_fault = bf; bus_fault_fetch = bff;
    refill_active = r; int_line = line; vec_space = sp; cur_pc = pc; fault_insn = insn;
    ec = ev ? c : (bff ? 6'h08 : 6'h09);
    m_err = !supp(ec);
    m_rv  = supp(ec);
    if (supp(ec)) begin
      if (ec == 6'h1A || (ec == 6'h00 && m_dact)) begin
        m_dret = pc; m_dact = 1;
        if (ec == 6'h1A) begin m_dbp = 1; m_dcode = 6'h0C; end
        else m_dint = 1;
        m_rpc = BASE + 32'h480;
      end else begin
        if (ec != 6'h00 && ec != 6'h03) m_badi = insn;
        if (r) begin
          m_rspl = m_plv; m_rsie = m_ie; m_da = 1; m_pg = 0; m_rret = pc[31:2];
        end else begin
          m_cause = ec; m_spl = m_plv; m_sie = m_ie; m_ret = pc;
        end
        m_plv = 0; m_ie = 0;
        if (ec == 6'h00)  m_rpc = BASE + (32'd64 + 32'(line)) * 32'(sp);
        else if (r)       m_rpc = RBASE;
        else              m_rpc = BASE + 32'(ec) * 32'(sp);
      end
    end
    @(negedge clk);
    exc_valid = 0; bus_fault = 0; mode_wr_en = 0;
    compare_all(tag);
  endtask

  task automatic idle_check();
    @(negedge clk);
    m_rv = 0; m_err = 0;
    chk("R11", "redirect_valid idle", 64'(redirect_valid), 64'(0));
    chk("R11", "redirect_pc hold", 64'(redirect_pc), 64'(m_rpc));
    chk("R10", "code_err idle", 64'(code_err), 64'(0));
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    @(negedge clk);
    chk("R1", "datf", 64'(datf), 64'(1));
    chk("R1", "datm", 64'(datm), 64'(1));
    compare_all("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R12: mode load, then an entry saves what was loaded
    mode_wr(2'd3, 1'b1, 1'b0, 1'b1);
    fire(1, 6'h0B, 0, 0, 0, 4'd0, 8'd16, 32'h0000_4004, 32'hDEAD_BEEF, "R2");
    idle_check();

    // R5: interrupt vectors over every line, alternating normal and refill routes
    for (int ln = 0; ln < 16; ln++) begin
      mode_wr(2'(ln), ln[1], ln[2], ln[3]);
      fire(1, 6'h00, 0, 0, ln[0], 4'(ln), 8'(4 << (ln % 4)),
           32'h3000_0000 + 32'(ln * 16), 32'h1111_0000 + 32'(ln), "R5");
    end

    // R9: bus faults on both routes, and request priority
    mode_wr(2'd1, 1'b1, 1'b0, 1'b1);
    fire(0, 6'h00, 1, 1, 0, 4'd0, 8'd32, 32'h0000_8000, 32'hAAAA_0001, "R9");
    mode_wr(2'd2, 1'b0, 1'b0, 1'b1);
    fire(0, 6'h00, 1, 0, 0, 4'd0, 8'd32, 32'h0000_8010, 32'hAAAA_0002, "R9");
    fire(0, 6'h00, 1, 0, 1, 4'd0, 8'd32, 32'h0000_8020, 32'hAAAA_0003, "R9");
    fire(1, 6'h0B, 1, 1, 0, 4'd0, 8'd32, 32'h0000_8030, 32'hAAAA_0004, "R9");

    // R12: a request in the same cycle blocks the mode load
    mode_wr(2'd3, 1'b1, 1'b1, 1'b1);
    mode_wr_en = 1; mode_wr_plv = 2'd2; mode_wr_ie = 1; mode_wr_da = 0; mode_wr_pg = 1;
    fire(1, 6'h0C, 0, 0, 0, 4'd0, 8'd8, 32'h0000_9000, 32'hBBBB_0000, "R12");
    mode_wr(2'd1, 1'b1, 1'b1, 1'b0);
    mode_wr_en = 1; mode_wr_plv = 2'd2; mode_wr_ie = 0; mode_wr_da = 0; mode_wr_pg = 1;
    fire(1, 6'h2C, 0, 0, 0, 4'd0, 8'd8, 32'h0000_9100, 32'hBBBB_0001, "R12");

    // R2 R4 R6 R10: sweep every code on both routes (debug code saved for last)
    for (int c = 1; c < 64; c++) begin
      for (int r = 0; r < 2; r++) begin
        if (c != 32'h1A) begin
          mode_wr(2'(c + r), c[0] ^ r[0], c[1], c[2]);
          fire(1, 6'(c), 0, 0, r[0], 4'(c), 8'(8 << (c % 4)),
               32'h9000_0000 + 32'(c << 8) + 32'(r << 4) + 32'hC,
               32'hA5A5_0000 ^ 32'(c << 1) ^ 32'(r), r ? "R4" : "R2");
        end
      end
    end
    idle_check();

    // R7 then R8: breakpoint, then an interrupt while in debug mode
    mode_wr(2'd3, 1'b1, 1'b0, 1'b1);
    fire(1, 6'h1A, 0, 0, 0, 4'd0, 8'd8, 32'h0000_A000, 32'hCCCC_0000, "R7");
    fire(1, 6'h00, 0, 0, 1, 4'd5, 8'd8, 32'h0000_A100, 32'hCCCC_0001, "R8");
    fire(1, 6'h0D, 0, 0, 0, 4'd0, 8'd16, 32'h0000_A200, 32'hCCCC_0002, "R2");
    idle_check();

    // R1: reset returns everything to its initial values
    do_reset();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule